// File: doc/BRIEF.md
# Register-Array RAM with Per-Port Collision Policy

This block is a small memory built from flip-flops. It has one write port and `NUM_RD` synchronous read ports, and all of them run on one clock. A write updates only the bits of the addressed word whose bit-enable is set. Each read port returns its word through an output register one clock edge after the address is sampled.

Each read port is configured at elaboration time for the case where it reads the address being written in the same cycle. It can return the new data, the old data, or an undefined word. Each read port also has its own output-register controls:

- an active-low asynchronous reset;
- a synchronous reset;
- a read enable;
- separate constant values for the asynchronous reset, the synchronous reset and the power-up state.

A per-port mask bit decides whether the synchronous reset is gated by the read enable.

Top module: `mpram`

## Requirements
- R1: Only the word at `wr_addr_i` changes on a write, and in it only the bits whose `wr_be_i` bit is 1. An all-zero `wr_be_i` is not a write.
- R2: When port p has its read enable set, its reset released and no collision, `rd_data_o[p]` shows the stored word at `rd_addr_i[p]` after the next rising edge.
- R3: A collision is a read of the address that `wr_addr_i` names while `wr_be_i` is non-zero. On a port whose `TRANSP_MASK` bit is 1, a collision returns the written value in the enabled bits and the stored value in the other bits.
- R4: On a port whose `TRANSP_MASK` and `COLLX_MASK` bits are both 0, a collision returns the word stored before the write.
- R5: On a port whose `COLLX_MASK` bit is 1 and whose `TRANSP_MASK` bit is 0, a collision returns all-X when `COLL_X_SIM` is 1 and the old word when it is 0. If both mask bits are set, transparency wins.
- R6: While `rd_rst_ni[p]` is low, `rd_data_o[p]` equals slice p of `ARST_VAL`, with no clock edge needed. Other ports are not affected.
- R7: On a port whose `SRST_GATED` bit is 0, `rd_srst_i[p]` loads slice p of `SRST_VAL` at the edge whatever the read enable is. Reset has priority over a read.
- R8: On a port whose `SRST_GATED` bit is 1, the synchronous reset acts only in a cycle with the read enable high. With the enable low, it is ignored and the output holds.
- R9: Before any reset or read, `rd_data_o[p]` holds slice p of `INIT_VAL`.
- R10: With the read enable low and no reset acting, the output register keeps its value even while writes change the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for all ports |
| rd_rst_ni | input | NUM_RD | Per-port active-low asynchronous reset of the output register |
| rd_srst_i | input | NUM_RD | Per-port synchronous reset of the output register |
| rd_en_i | input | NUM_RD | Per-port read enable |
| rd_addr_i | input | NUM_RD*ADDR_W | Read addresses; port p in slice p |
| rd_data_o | output | NUM_RD*DATA_W | Registered read data; port p in slice p |
| wr_be_i | input | DATA_W | Per-bit write enable |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | DATA_W | Write data |

## Verification
The bench builds the block with three read ports, 4-bit words and four words, and sets `COLL_X_SIM` to 0. Port 0 is transparent with an enable-gated synchronous reset. Port 1 returns old data. Port 2 is marked undefined-on-collision, so it resolves to old data in this build.

This small build allows all 16 bit-enable patterns at every address to be swept while all three ports collide with the write. Each collision is followed by a plain readback, which covers the merge of new and old bits and the partial updates of the array exhaustively. Reset priority and hold are then exercised port against port, since the three ports differ in their settings.

// File: rtl/mpram_pkg.sv
package mpram_pkg;

  typedef enum logic [1:0] {
    COLL_OLD   = 2'd0,
    COLL_NEW   = 2'd1,
    COLL_UNDEF = 2'd2
  } coll_mode_e;

  // transparency wins over undefined-on-collision
  function automatic coll_mode_e coll_mode(input logic transp, input logic collx);
    if (transp) return COLL_NEW;
    if (collx) return COLL_UNDEF;
    return COLL_OLD;
  endfunction

endpackage

// File: rtl/mpram_array.sv
module mpram_array #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned NUM_RD = 2
) (
  input  logic                       clk_i,
  input  logic [DATA_W-1:0]          wr_be_i,
  input  logic [ADDR_W-1:0]          wr_addr_i,
  input  logic [DATA_W-1:0]          wr_data_i,
  input  logic [NUM_RD*ADDR_W-1:0]   rd_addr_i,
  output logic [NUM_RD*DATA_W-1:0]   rd_old_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    for (int b = 0; b < DATA_W; b++) begin
      if (wr_be_i[b]) mem_q[wr_addr_i][b] <= wr_data_i[b];
    end
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    assign rd_old_o[p*DATA_W +: DATA_W] = mem_q[rd_addr_i[p*ADDR_W +: ADDR_W]];
  end

endmodule

// File: rtl/mpram_rd_port.sv
module mpram_rd_port #(
  parameter int unsigned            DATA_W     = 8,
  parameter int unsigned            ADDR_W     = 4,
  parameter mpram_pkg::coll_mode_e  MODE       = mpram_pkg::COLL_OLD,
  parameter bit                     GATED      = 1'b0,
  parameter bit                     X_SIM      = 1'b0,
  parameter logic [DATA_W-1:0]      INIT       = '0,
  parameter logic [DATA_W-1:0]      ARST       = '0,
  parameter logic [DATA_W-1:0]      SRST       = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              srst_i,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] old_i,
  input  logic [DATA_W-1:0] wr_be_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] data_o
);
  logic              hit;
  logic [DATA_W-1:0] rd_val;
  logic [DATA_W-1:0] data_q = INIT;

  assign hit = (|wr_be_i) && (addr_i == wr_addr_i);

  always_comb begin
    rd_val = old_i;
    if (hit) begin
      unique case (MODE)
        mpram_pkg::COLL_NEW:   rd_val = (old_i & ~wr_be_i) | (wr_data_i & wr_be_i);
        mpram_pkg::COLL_UNDEF: rd_val = X_SIM ? 'x : old_i;
        default:               rd_val = old_i;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= ARST;
    end else if (GATED) begin
      if (en_i) data_q <= srst_i ? SRST : rd_val;
    end else begin
      if (srst_i)    data_q <= SRST;
      else if (en_i) data_q <= rd_val;
    end
  end

  assign data_o = data_q;

endmodule

// File: rtl/mpram.sv
module mpram #(
  parameter int unsigned               DATA_W      = 8,
  parameter int unsigned               ADDR_W      = 4,
  parameter int unsigned               NUM_RD      = 2,
  parameter logic [NUM_RD-1:0]         TRANSP_MASK = '0,
  parameter logic [NUM_RD-1:0]         COLLX_MASK  = '0,
  parameter logic [NUM_RD-1:0]         SRST_GATED  = '0,
  parameter bit                        COLL_X_SIM  = 1'b1,
  parameter logic [NUM_RD*DATA_W-1:0]  INIT_VAL    = '0,
  parameter logic [NUM_RD*DATA_W-1:0]  ARST_VAL    = '0,
  parameter logic [NUM_RD*DATA_W-1:0]  SRST_VAL    = '0
) (
  input  logic                       clk_i,
  input  logic [NUM_RD-1:0]          rd_rst_ni,
  input  logic [NUM_RD-1:0]          rd_srst_i,
  input  logic [NUM_RD-1:0]          rd_en_i,
  input  logic [NUM_RD*ADDR_W-1:0]   rd_addr_i,
  output logic [NUM_RD*DATA_W-1:0]   rd_data_o,
  input  logic [DATA_W-1:0]          wr_be_i,
  input  logic [ADDR_W-1:0]          wr_addr_i,
  input  logic [DATA_W-1:0]          wr_data_i
);
  logic [NUM_RD*DATA_W-1:0] rd_old;

  mpram_array #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_RD(NUM_RD)
  ) u_array (
    .clk_i     (clk_i),
    .wr_be_i   (wr_be_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr_i),
    .rd_old_o  (rd_old)
  );

  for (genvar p = 0; p < NUM_RD; p++) begin : g_port
    mpram_rd_port #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W),
      .MODE   (mpram_pkg::coll_mode(TRANSP_MASK[p], COLLX_MASK[p])),
      .GATED  (SRST_GATED[p]),
      .X_SIM  (COLL_X_SIM),
      .INIT   (INIT_VAL[p*DATA_W +: DATA_W]),
      .ARST   (ARST_VAL[p*DATA_W +: DATA_W]),
      .SRST   (SRST_VAL[p*DATA_W +: DATA_W])
    ) u_rd (
      .clk_i     (clk_i),
      .rst_ni    (rd_rst_ni[p]),
      .srst_i    (rd_srst_i[p]),
      .en_i      (rd_en_i[p]),
      .addr_i    (rd_addr_i[p*ADDR_W +: ADDR_W]),
      .old_i     (rd_old[p*DATA_W +: DATA_W]),
      .wr_be_i   (wr_be_i),
      .wr_addr_i (wr_addr_i),
      .wr_data_i (wr_data_i),
      .data_o    (rd_data_o[p*DATA_W +: DATA_W])
    );
  end

endmodule

// File: rtl/mpram_chk.sv
module mpram_chk #(
  parameter int unsigned               DATA_W      = 8,
  parameter int unsigned               ADDR_W      = 4,
  parameter int unsigned               NUM_RD      = 2,
  parameter logic [NUM_RD-1:0]         TRANSP_MASK = '0,
  parameter logic [NUM_RD-1:0]         SRST_GATED  = '0,
  parameter logic [NUM_RD*DATA_W-1:0]  ARST_VAL    = '0,
  parameter logic [NUM_RD*DATA_W-1:0]  SRST_VAL    = '0
) (
  input logic                       clk_i,
  input logic [NUM_RD-1:0]          rd_rst_ni,
  input logic [NUM_RD-1:0]          rd_srst_i,
  input logic [NUM_RD-1:0]          rd_en_i,
  input logic [NUM_RD*ADDR_W-1:0]   rd_addr_i,
  input logic [NUM_RD*DATA_W-1:0]   rd_data_o,
  input logic [DATA_W-1:0]          wr_be_i,
  input logic [ADDR_W-1:0]          wr_addr_i,
  input logic [DATA_W-1:0]          wr_data_i
);
  for (genvar p = 0; p < NUM_RD; p++) begin : g_chk
    // R6
    arst_value_chk: assert property (@(posedge clk_i)
      !rd_rst_ni[p] |-> rd_data_o[p*DATA_W +: DATA_W] == ARST_VAL[p*DATA_W +: DATA_W]);

    // R7
    srst_load_chk: assert property (@(posedge clk_i) disable iff (!rd_rst_ni[p])
      (rd_srst_i[p] && (!SRST_GATED[p] || rd_en_i[p]))
      |=> rd_data_o[p*DATA_W +: DATA_W] == SRST_VAL[p*DATA_W +: DATA_W]);

    // R10
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rd_rst_ni[p])
      (!rd_en_i[p] && (SRST_GATED[p] || !rd_srst_i[p]))
      |=> $stable(rd_data_o[p*DATA_W +: DATA_W]));

    if (TRANSP_MASK[p]) begin : g_tr
      // R3
      transp_new_bits_chk: assert property (@(posedge clk_i) disable iff (!rd_rst_ni[p])
        (rd_en_i[p] && !rd_srst_i[p] && (rd_addr_i[p*ADDR_W +: ADDR_W] == wr_addr_i))
        |=> ((rd_data_o[p*DATA_W +: DATA_W] ^ $past(wr_data_i)) & $past(wr_be_i)) == '0);
    end
  end
endmodule

bind mpram mpram_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_RD(NUM_RD),
  .TRANSP_MASK(TRANSP_MASK), .SRST_GATED(SRST_GATED),
  .ARST_VAL(ARST_VAL), .SRST_VAL(SRST_VAL)
) u_chk (
  .clk_i(clk_i), .rd_rst_ni(rd_rst_ni), .rd_srst_i(rd_srst_i), .rd_en_i(rd_en_i),
  .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .wr_be_i(wr_be_i),
  .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i)
);

// File: tb/mpram_tb.sv
module mpram_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 4;
  localparam int AW = 2;
  localparam int NR = 3;
  localparam logic [NR*DW-1:0] INIT = 12'h765;
  localparam logic [NR*DW-1:0] ARST = 12'h321;
  localparam logic [NR*DW-1:0] SRST = 12'hDB9;

  logic clk = 1'b0;
  logic [NR-1:0]    rst_n = '1;
  logic [NR-1:0]    srst = '0;
  logic [NR-1:0]    en = '0;
  logic [NR*AW-1:0] raddr = '0;
  logic [NR*DW-1:0] rdata;
  logic [DW-1:0]    wbe = '0;
  logic [AW-1:0]    waddr = '0;
  logic [DW-1:0]    wdata = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [DW-1:0] m_mem [4];
  logic [DW-1:0] m_q [NR];

  always #(CLK_PERIOD/2) clk = ~clk;

  mpram #(
    .DATA_W(DW), .ADDR_W(AW), .NUM_RD(NR),
    .TRANSP_MASK(3'b001), .COLLX_MASK(3'b100), .SRST_GATED(3'b001),
    .COLL_X_SIM(1'b0), .INIT_VAL(INIT), .ARST_VAL(ARST), .SRST_VAL(SRST)
  ) u_dut (
    .clk_i(clk), .rd_rst_ni(rst_n), .rd_srst_i(srst), .rd_en_i(en),
    .rd_addr_i(raddr), .rd_data_o(rdata), .wr_be_i(wbe),
    .wr_addr_i(waddr), .wr_data_i(wdata)
  );

  function automatic logic [DW-1:0] sl(input logic [NR*DW-1:0] v, input int p);
    return v[p*DW +: DW];
  endfunction

  task automatic chk(input string tag, input int p, input logic [DW-1:0] exp);
    logic [DW-1:0] got;
    got = rdata[p*DW +: DW];
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s port %0d: got %h expected %h", tag, p, got, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    for (int p = 0; p < NR; p++) chk(tag, p, m_q[p]);
  endtask

  // reference model for one edge, then compare just after it
  task automatic step(input string tag);
    logic [DW-1:0] old, rd;
    logic [AW-1:0] ra;
    logic hit;
    for (int p = 0; p < NR; p++) begin
      ra = raddr[p*AW +: AW];
      old = m_mem[ra];
      hit = (wbe != 0) && (ra == waddr);
      rd = (p == 0 && hit) ? ((old & ~wbe) | (wdata & wbe)) : old;
      if (!rst_n[p]) m_q[p] = sl(ARST, p);
      else if (p == 0) begin
        if (en[p]) m_q[p] = srst[p] ? sl(SRST, p) : rd;
      end else begin
        if (srst[p]) m_q[p] = sl(SRST, p);
        else if (en[p]) m_q[p] = rd;
      end
    end
    for (int b = 0; b < DW; b++) if (wbe[b]) m_mem[waddr][b] = wdata[b];
    @(posedge clk);
    #1;
    chk_all(tag);
  endtask

  task automatic set_rd(input logic [AW-1:0] a0, input logic [AW-1:0] a1, input logic [AW-1:0] a2);
    raddr = {a2, a1, a0};
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    for (int p = 0; p < NR; p++) m_q[p] = sl(INIT, p);
    #1;
    chk_all("R9 initial value");

    // async reset acts without an edge
    #1;
    rst_n = '0;
    for (int p = 0; p < NR; p++) m_q[p] = sl(ARST, p);
    #1;
    chk_all("R6 async reset immediate");
    en = '1;
    srst = '1;
    step("R6 async reset dominates");
    rst_n = '1;
    srst = '0;
    en = '0;

    // fill the array while ports idle
    for (int a = 0; a < 4; a++) begin
      wbe = '1; waddr = a[AW-1:0]; wdata = 4'(a * 5 + 2);
      step("R10 hold during fill");
    end
    wbe = '0;

    // exhaustive collision sweep with readback
    for (int a = 0; a < 4; a++) begin
      for (int be = 0; be < 16; be++) begin
        set_rd(a[AW-1:0], a[AW-1:0], a[AW-1:0]);
        en = '1;
        waddr = a[AW-1:0];
        wbe = be[DW-1:0];
        wdata = ~m_mem[a];
        step("R3/R4/R5 collision");
        wbe = '0;
        step("R1/R2 readback");
      end
    end

    // reads of other addresses during a write
    for (int a = 0; a < 4; a++) begin
      set_rd(a[AW-1:0], 2'(a + 2), 2'(a + 3));
      en = '1;
      wbe = '1; waddr = 2'(a + 1); wdata = 4'(a * 3 + 9);
      step("R2 no collision");
    end
    wbe = '0;
    set_rd(2'd0, 2'd1, 2'd2);
    step("R1/R2 read after write");

    // hold with enable low while array changes
    en = '0;
    set_rd(2'd1, 2'd1, 2'd1);
    wbe = '1; waddr = 2'd1; wdata = 4'hF;
    step("R10 hold while writing");
    wbe = '0;
    step("R10 hold idle");

    // sync reset with enable low: ungated ports load, gated port holds
    srst = '1;
    step("R7/R8 srst enable low");
    srst = '0;
    en = '1;
    step("R2 read after srst");
    srst = '1;
    step("R7/R8 srst enable high");
    srst = '0;
    step("R2 read after srst high");

    // async reset on one port only
    #2;
    rst_n = 3'b101;
    m_q[1] = sl(ARST, 1);
    #1;
    chk_all("R6 single port reset");
    step("R6 single port reset edge");
    rst_n = '1;
    step("R6 after release");

    finish_run();
  end

endmodule